// File: doc/BRIEF.md
# Low-First PWM Timer Channel

A single PWM channel built around a 24-bit up-counter that advances on a prescaled tick. Every period has two phases. The output starts each period in its low phase, which lasts for a programmed number of counts. It then stays high until the counter wraps. A polarity bit swaps the two output levels. The low-phase width goes through a shadow register, so a new duty setting takes effect on a period boundary and never part-way through a period.

Software drives the block through a small word-addressed register port that runs on the same clock as the counter. It sets the period, the low width, the prescale code and the polarity, and it starts or stops the counter with an enable bit. Three sticky event flags record output rising edges, output falling edges and counter wraps. A per-flag mask selects which flags drive the single interrupt line.

Top module: `lowfirst_pwm`

## Requirements
- R1: After reset every register reads 0 and both `pwm_out` and `irq` are 0.
- R2: A period spans the period register value plus one prescaled counts. The count readable at offset 0xC steps from 0 up to the period value and then returns to 0.
- R3: The prescale code in control bits 17:16 sets the tick rate: 0 ticks every clock, 1 every 16 clocks, 2 every 256 clocks and 3 every 2048 clocks.
- R4: Each period begins low for the number of counts in the low-width register (offset 0x8) and is high for the remaining counts.
- R5: A low width of 0 keeps the output high at all times. A low width greater than the period value keeps it low at all times.
- R6: A write to the low width changes the waveform only from the next period boundary onward.
- R7: Control bit 3 inverts both output levels.
- R8: While the enable bit (control bit 1) is 1, writes to the period register (offset 0x4), the polarity bit and the prescale field are ignored.
- R9: Clearing the enable bit returns the counter and prescaler to 0 and drives `pwm_out` to the value of the polarity bit.
- R10: Status at offset 0x10 holds bit 0 for an output rising edge, bit 1 for an output falling edge and bit 2 for a counter wrap. Each bit stays set until software writes 1 to it.
- R11: `irq` is the OR of the status bits that are enabled in the mask register at offset 0x14, delayed by one clock.
- R12: The control register is at offset 0x0. Bit 2 is a mode bit that is stored and read back and has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counter |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| pwm_out | output | 1 | Registered PWM output |
| irq | output | 1 | Registered masked interrupt request |

## Verification
On every clock, the assertions check four things: the count never passes the period value, the prescaler stays inside its divide window, and the active low width and the locked fields do not change while the channel runs. They also check that a stopped channel holds its counter at zero with the output at the polarity level, and that the status flags stay set until a write clears them. Some behaviours can only be shown by the bench's scenarios, because they depend on the waveform as a whole. These are the measured high and low time across whole periods for every prescale code, the deferred effect of a duty write, and the 0% and 100% encodings.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PS_MAX_SHIFT = 11;
  localparam int PRE_W        = PS_MAX_SHIFT;

  localparam logic [4:0] OFS_CTRL  = 5'h00;
  localparam logic [4:0] OFS_CYC   = 5'h04;
  localparam logic [4:0] OFS_LOW   = 5'h08;
  localparam logic [4:0] OFS_COUNT = 5'h0C;
  localparam logic [4:0] OFS_STAT  = 5'h10;
  localparam logic [4:0] OFS_MASK  = 5'h14;

  typedef enum logic [1:0] {EV_RISE = 2'd0, EV_FALL = 2'd1, EV_WRAP = 2'd2} ev_idx_e;
  localparam int N_EV = 3;

  // terminal prescaler value for a 2-bit code: shifts 0, 4, 8, 11
  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] code);
    int sh;
    sh = (code == 2'd3) ? PS_MAX_SHIFT : 4 * int'(code);
    return PRE_W'((32'd1 << sh) - 32'd1);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim  = pre_limit(code);
  assign tick = run && (pre_q == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (tick)   pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R3: the divider never runs past its window
  a_r3_pre_window: assert property (@(posedge clk) disable iff (rst)
    run |-> pre_q <= lim);
  // R9: a stopped channel clears its prescaler
  a_r9_pre_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> pre_q == '0);
endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             inv,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] low_shadow,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             pwm_out
);
  logic [CNT_W-1:0] low_act;
  logic             in_high;

  assign wrap    = tick && (cnt == cyc);
  assign in_high = (cnt >= low_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      low_act <= '0;
      pwm_out <= 1'b0;
    end else if (!run) begin
      cnt     <= '0;
      low_act <= low_shadow;
      pwm_out <= inv;
    end else begin
      if (wrap) begin
        cnt     <= '0;
        low_act <= low_shadow;
      end else if (tick) begin
        cnt     <= cnt + 1'b1;
      end
      pwm_out <= in_high ^ inv;
    end
  end

  // R2: the count stays within the period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt <= cyc);
  // R6: the active low width only moves at a period boundary
  a_r6_low_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> $stable(low_act));
  // R9: stopped channel sits at zero with the polarity level
  a_r9_idle_out: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0) && (pwm_out == $past(inv)));
endmodule

// File: rtl/pwm_irq.sv
module pwm_irq
  import pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_out,
  input  logic            wrap,
  input  logic [N_EV-1:0] w1c,
  input  logic [N_EV-1:0] mask,
  output logic [N_EV-1:0] status,
  output logic            irq
);
  logic            prev_q;
  logic [N_EV-1:0] ev;

  always_comb begin
    ev          = '0;
    ev[EV_RISE] = pwm_out && !prev_q;
    ev[EV_FALL] = !pwm_out && prev_q;
    ev[EV_WRAP] = wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      prev_q <= pwm_out;
      status <= (status & ~w1c) | ev;
      irq    <= |(status & mask);
    end
  end

  generate
    for (genvar i = 0; i < N_EV; i++) begin : g_sticky
      // R10: a flag holds until written with 1
      a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (status[i] && !w1c[i]) |=> status[i]);
    end
  endgenerate

  // R10: an output rising edge is recorded
  a_r10_rise_seen: assert property (@(posedge clk) disable iff (rst)
    (pwm_out && !prev_q) |=> status[EV_RISE]);
  // R11: nothing enabled means no request
  a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
    ((status & mask) == '0) |=> !irq);
endmodule

// File: rtl/lowfirst_pwm.sv
module lowfirst_pwm
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_out,
  output logic              irq
);
  localparam int EN_BIT   = 1;
  localparam int MODE_BIT = 2;
  localparam int INV_BIT  = 3;
  localparam int PS_LSB   = 16;

  logic             en_q, mode_q, inv_q;
  logic [1:0]       ps_q;
  logic [CNT_W-1:0] cyc_q, low_sh_q, cnt;
  logic [N_EV-1:0]  mask_q, status, w1c;
  logic             tick, wrap;
  logic [4:0]       ofs;
  logic [DATA_W-1:0] rd_mux;

  assign ofs = 5'(addr);
  assign w1c = (wr_en && ofs == OFS_STAT) ? wdata[N_EV-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; mode_q <= 1'b0; inv_q <= 1'b0; ps_q <= '0;
      cyc_q <= '0; low_sh_q <= '0; mask_q <= '0;
    end else if (wr_en) begin
      case (ofs)
        OFS_CTRL: begin
          en_q   <= wdata[EN_BIT];
          mode_q <= wdata[MODE_BIT];
          if (!en_q) begin
            inv_q <= wdata[INV_BIT];
            ps_q  <= wdata[PS_LSB+1:PS_LSB];
          end
        end
        OFS_CYC:  if (!en_q) cyc_q <= wdata[CNT_W-1:0];
        OFS_LOW:  low_sh_q <= wdata[CNT_W-1:0];
        OFS_MASK: mask_q   <= wdata[N_EV-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (ofs)
      OFS_CTRL: begin
        rd_mux[EN_BIT]            = en_q;
        rd_mux[MODE_BIT]          = mode_q;
        rd_mux[INV_BIT]           = inv_q;
        rd_mux[PS_LSB+1:PS_LSB]   = ps_q;
      end
      OFS_CYC:   rd_mux[CNT_W-1:0] = cyc_q;
      OFS_LOW:   rd_mux[CNT_W-1:0] = low_sh_q;
      OFS_COUNT: rd_mux[CNT_W-1:0] = cnt;
      OFS_STAT:  rd_mux[N_EV-1:0]  = status;
      OFS_MASK:  rd_mux[N_EV-1:0]  = mask_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  pwm_prescaler u_pre (
    .clk(clk), .rst(rst), .run(en_q), .code(ps_q), .tick(tick)
  );

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run(en_q), .tick(tick), .inv(inv_q),
    .cyc(cyc_q), .low_shadow(low_sh_q), .cnt(cnt), .wrap(wrap),
    .pwm_out(pwm_out)
  );

  pwm_irq u_irq (
    .clk(clk), .rst(rst), .pwm_out(pwm_out), .wrap(wrap), .w1c(w1c),
    .mask(mask_q), .status(status), .irq(irq)
  );

  // R8: period, polarity and prescale are frozen while running
  a_r8_cyc_locked: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(cyc_q));
  a_r8_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    en_q |=> $stable(inv_q) && $stable(ps_q));
endmodule

// File: tb/lowfirst_pwm_test.sv
module lowfirst_pwm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_out, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lowfirst_pwm uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  ps;
    logic [23:0] cyc;
    logic [23:0] low;
    logic        inv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{ps:2'd0, cyc:24'd9, low:24'd3,  inv:1'b0},
    '{ps:2'd0, cyc:24'd9, low:24'd0,  inv:1'b0},
    '{ps:2'd0, cyc:24'd9, low:24'd12, inv:1'b0},
    '{ps:2'd1, cyc:24'd4, low:24'd2,  inv:1'b0},
    '{ps:2'd2, cyc:24'd2, low:24'd1,  inv:1'b1},
    '{ps:2'd3, cyc:24'd1, low:24'd1,  inv:1'b0},
    '{ps:2'd0, cyc:24'd9, low:24'd10, inv:1'b0},
    '{ps:2'd0, cyc:24'd9, low:24'd9,  inv:1'b1}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] ctrl_word(logic [1:0] ps, logic inv, logic en);
    return (32'(ps) << 16) | (32'(inv) << 3) | (32'(en) << 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d, d2;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 pwm_out", pwm_out, 0);
    check("R1 irq", irq, 0);
    rd(5'h00, d); check("R1 ctrl", d, 0);
    rd(5'h04, d); check("R1 cycle", d, 0);
    rd(5'h08, d); check("R1 low", d, 0);
    rd(5'h0C, d); check("R1 count", d, 0);
    rd(5'h10, d); check("R1 status", d, 0);

    // R3 R4 R5 R7: table walk, high time over two whole periods
    for (int v = 0; v < NV; v++) begin
      longint dv, lowc, highc, per, ones, expv;
      dv    = (VEC[v].ps == 2'd3) ? 2048 : (longint'(1) << (4 * VEC[v].ps));
      lowc  = (VEC[v].low > VEC[v].cyc) ? longint'(VEC[v].cyc) + 1 : longint'(VEC[v].low);
      highc = longint'(VEC[v].cyc) + 1 - lowc;
      per   = (longint'(VEC[v].cyc) + 1) * dv;
      expv  = VEC[v].inv ? 2 * lowc * dv : 2 * highc * dv;
      wr(5'h00, 32'h0);
      wr(5'h04, 32'(VEC[v].cyc));
      wr(5'h08, 32'(VEC[v].low));
      wr(5'h00, ctrl_word(VEC[v].ps, VEC[v].inv, 1'b1));
      repeat (8) @(negedge clk);
      ones = 0;
      for (longint k = 0; k < 2 * per; k++) begin
        if (pwm_out) ones++;
        @(negedge clk);
      end
      check($sformatf("R3/R4/R5/R7 vector %0d high time", v), ones, expv);
    end

    // R2: count repeats after exactly one period (cycle 9, prescale /1)
    wr(5'h00, 32'h0);
    wr(5'h04, 32'd9);
    wr(5'h08, 32'd3);
    wr(5'h00, ctrl_word(2'd0, 1'b0, 1'b1));
    repeat (5) @(negedge clk);
    rd(5'h0C, d);
    repeat (8) @(negedge clk);
    rd(5'h0C, d2);
    check("R2 count period", d2, d);
    check("R2 count bound", (d <= 9) ? 1 : 0, 1);

    // R6: deferred low-width update
    wr(5'h00, 32'h0);
    wr(5'h04, 32'd99);
    wr(5'h08, 32'd10);
    wr(5'h00, ctrl_word(2'd0, 1'b0, 1'b1));
    while (pwm_out !== 1'b0) @(negedge clk);
    while (pwm_out !== 1'b1) @(negedge clk);
    wr(5'h08, 32'd50);
    repeat (5) @(negedge clk);
    check("R6 old period kept high", pwm_out, 1);
    while (pwm_out === 1'b1) @(negedge clk);
    n = 0;
    while (pwm_out === 1'b0) begin n++; @(negedge clk); end
    check("R6 new low run", n, 50);

    // R8: locked fields while running
    wr(5'h04, 32'd5);
    rd(5'h04, d); check("R8 cycle ignored", d, 99);
    wr(5'h00, ctrl_word(2'd2, 1'b1, 1'b1));
    rd(5'h00, d); check("R8 polarity/prescale ignored", d, 32'h2);

    // R12: mode bit stored, waveform unaffected
    wr(5'h00, 32'h6);
    rd(5'h00, d); check("R12 mode readback", d, 32'h6);

    // R9: stopping
    wr(5'h00, 32'h0);
    repeat (3) @(negedge clk);
    rd(5'h0C, d); check("R9 count cleared", d, 0);
    check("R9 output idle low", pwm_out, 0);
    wr(5'h00, ctrl_word(2'd0, 1'b1, 1'b0));
    repeat (2) @(negedge clk);
    check("R9 output idle at polarity", pwm_out, 1);
    wr(5'h00, 32'h0);

    // R10 R11: flags and mask
    repeat (3) @(negedge clk);
    wr(5'h10, 32'h7);
    wr(5'h14, 32'h0);
    wr(5'h04, 32'd9);
    wr(5'h08, 32'd3);
    wr(5'h00, ctrl_word(2'd0, 1'b0, 1'b1));
    repeat (40) @(negedge clk);
    rd(5'h10, d); check("R10 all events flagged", d, 7);
    check("R11 masked irq low", irq, 0);
    wr(5'h14, 32'h4);
    repeat (2) @(negedge clk);
    check("R11 irq on wrap flag", irq, 1);
    wr(5'h00, 32'h0);
    repeat (3) @(negedge clk);
    wr(5'h10, 32'h7);
    repeat (2) @(negedge clk);
    rd(5'h10, d); check("R10 write-one clear", d, 0);
    check("R11 irq drops", irq, 0);

    finish_run();
  end
endmodule